// File: doc/BRIEF.md
# Frame-Synchronized ADC Data Port Receiver

This block receives conversion results from a multichannel delta-sigma converter over a one-lane serial data port that uses a frame-sync strobe instead of a chip select. The strobe, the data clock and the data lane come in asynchronously. Each one passes through a two-flop synchronizer, and the block finds data-clock rising edges in the system clock domain. The block uses a fast system clock, at least four system cycles per data-clock phase.

A frame starts on each rising edge of the frame-sync strobe. The block shifts in one 24-bit two's-complement word per channel, most significant bit first, with channel 0 first. After the last channel bit it latches all words onto a parallel output and pulses a frame-valid strobe for one system cycle. The converter passes daisy-chain bits through after the last channel. With the chain input tied high these bits must all be ones, so a zero among them sets a sticky error flag. If the strobe rises again before a frame is complete, the partial frame is dropped and a sticky short-frame flag is set.

The control is a three-state machine. In IDLE the block waits for the first strobe edge. In CAPTURE it counts and shifts channel bits. In FILLER it checks the trailing bits. The transitions are: IDLE to CAPTURE on a strobe rise; CAPTURE to FILLER on the last channel bit; CAPTURE to CAPTURE on a strobe rise, which restarts the frame and flags it short; FILLER to CAPTURE on a strobe rise. A strobe rise always clears the bit counter.

Top module: `fsync_adc_rx`

## Requirements
- R1: During reset and right after it, `frame_valid_o`, `filler_error_o` and `short_frame_o` are 0 and `samples_o` is all zeros.
- R2: Data-clock edges seen before the first frame-sync rising edge shift nothing in and produce no `frame_valid_o` pulse.
- R3: Data is taken on data-clock rising edges, 24 bits per channel, MSB first, channel 0 first. Channel k appears on `samples_o[(CHANNELS-k)*SAMPLE_W-1 -: SAMPLE_W]`, so channel 0 is in the top 24 bits.
- R4: `frame_valid_o` goes high for exactly one system cycle after the 192nd bit of a frame. `samples_o` changes only together with that pulse and holds its value at all other times.
- R5: Each 24-bit word is delivered bit-exact, with its sign kept. Examples are 0x000001, 0xFFFFFF (-1), 0x7FFFFF and 0x800000.
- R6: Trailing bits after bit 192 that are all 1 leave `filler_error_o` at 0.
- R7: A 0 on the lane at any data-clock rising edge after bit 192 and before the next frame-sync rise sets `filler_error_o`. The flag then stays at 1 until reset.
- R8: A frame-sync rise during CAPTURE drops the partial frame: there is no pulse and `samples_o` is unchanged. It also sets `short_frame_o`, which stays at 1 until reset.
- R9: The frame-sync rise that ends a short frame starts a new capture, and that frame is delivered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the data clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync_in | input | 1 | Frame-sync strobe, asynchronous |
| dclk_in | input | 1 | Serial data clock, asynchronous |
| dout_in | input | 1 | Serial data lane, asynchronous |
| samples_o | output | CHANNELS*SAMPLE_W | Latched channel words, channel 0 in the top bits |
| frame_valid_o | output | 1 | One-cycle strobe when a new frame is latched |
| filler_error_o | output | 1 | Sticky flag: a trailing bit read as 0 |
| short_frame_o | output | 1 | Sticky flag: a frame ended before all channel bits arrived |

## Verification
The bound checker checks on every cycle that the frame-valid strobe lasts one cycle and is raised only once the machine has reached FILLER. It also checks that the parallel output holds its value between strobes, that both error flags stay set once raised, and that reset leaves the outputs clear. Only the bench scenarios can show that bits land in the right channel and position with their sign intact. The same holds for ignoring bits before the first frame, dropping a truncated frame and recovering on the next one, and telling trailing ones apart from a single zero.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_FILLER  = 2'd2
    } fsrx_state_e;
endpackage

// File: rtl/fsrx_sync.sv
module fsrx_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fsrx_rise.sv
module fsrx_rise #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/fsrx_sample_bank.sv
module fsrx_sample_bank #(
    parameter int TOTAL_BITS = 192
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic                  load_en,
    input  logic                  bit_in,
    output logic [TOTAL_BITS-1:0] words
);
    logic [TOTAL_BITS-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            words   <= '0;
        end else begin
            if (shift_en) shreg_q <= {shreg_q[TOTAL_BITS-2:0], bit_in};
            if (load_en)  words   <= {shreg_q[TOTAL_BITS-2:0], bit_in};
        end
    end
endmodule

// File: rtl/fsync_adc_rx.sv
module fsync_adc_rx #(
    parameter int CHANNELS    = 8,
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fsync_in,
    input  logic                         dclk_in,
    input  logic                         dout_in,
    output logic [CHANNELS*SAMPLE_W-1:0] samples_o,
    output logic                         frame_valid_o,
    output logic                         filler_error_o,
    output logic                         short_frame_o
);
    import fsrx_pkg::*;

    localparam int TOTAL_BITS = CHANNELS * SAMPLE_W;
    localparam int CNT_W      = $clog2(TOTAL_BITS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL_BITS - 1);

    logic [2:0]      sync_vec;
    logic [1:0]      rise_vec;
    logic            fs_rise, dclk_rise, dat_s;
    fsrx_state_e     state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic            last_bit, shift_en, load_en, filler_hit, short_hit;

    fsrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({fsync_in, dclk_in, dout_in}),
        .q     (sync_vec)
    );

    fsrx_rise #(.WIDTH(2)) rise_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sync_vec[2:1]),
        .rise  (rise_vec)
    );

    assign fs_rise   = rise_vec[1];
    assign dclk_rise = rise_vec[0];
    assign dat_s     = sync_vec[0];

    // Next-state logic; a strobe edge wins over a coincident clock edge.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (fs_rise) state_d = ST_CAPTURE;
            ST_CAPTURE: begin
                if (fs_rise)                    state_d = ST_CAPTURE;
                else if (dclk_rise && last_bit) state_d = ST_FILLER;
            end
            ST_FILLER:  if (fs_rise) state_d = ST_CAPTURE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign last_bit   = (bit_cnt_q == LAST_IDX);
    assign shift_en   = (state_q == ST_CAPTURE) && dclk_rise && !fs_rise;
    assign load_en    = shift_en && last_bit;
    assign filler_hit = (state_q == ST_FILLER) && dclk_rise && !fs_rise && !dat_s;
    assign short_hit  = (state_q == ST_CAPTURE) && fs_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q      <= '0;
            frame_valid_o  <= 1'b0;
            filler_error_o <= 1'b0;
            short_frame_o  <= 1'b0;
        end else begin
            if (fs_rise)       bit_cnt_q <= '0;
            else if (shift_en) bit_cnt_q <= bit_cnt_q + 1'b1;
            frame_valid_o  <= load_en;
            filler_error_o <= filler_error_o | filler_hit;
            short_frame_o  <= short_frame_o | short_hit;
        end
    end

    fsrx_sample_bank #(.TOTAL_BITS(TOTAL_BITS)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .load_en  (load_en),
        .bit_in   (dat_s),
        .words    (samples_o)
    );
endmodule

// File: rtl/fsrx_chk.sv
module fsrx_chk #(
    parameter int TOTAL_BITS = 192
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     frame_valid,
    input logic                     filler_error,
    input logic                     short_frame,
    input logic [TOTAL_BITS-1:0]    samples,
    input fsrx_pkg::fsrx_state_e    state
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!frame_valid && !filler_error && !short_frame && samples == '0));

    assert_valid_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_valid_after_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> state == fsrx_pkg::ST_FILLER);

    assert_samples_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> $stable(samples));

    assert_filler_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        filler_error |=> filler_error);

    assert_short_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        short_frame |=> short_frame);
endmodule

bind fsync_adc_rx fsrx_chk #(.TOTAL_BITS(TOTAL_BITS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_valid  (frame_valid_o),
    .filler_error (filler_error_o),
    .short_frame  (short_frame_o),
    .samples      (samples_o),
    .state        (state_q)
);

// File: tb/fsync_adc_rx_tb_top.sv
module fsync_adc_rx_tb_top;
    localparam int NCH = 8;
    localparam int W   = 24;
    localparam int TB  = NCH * W;
    localparam int NVEC = 4;

    localparam logic [TB-1:0] VEC [NVEC] = '{
        {24'h000001, 24'h000000, 24'hFFFFFF, 24'hFFFFFE, 24'h000010, 24'hFFFFF0, 24'h000100, 24'hFFFF00},
        {24'h7FFFFF, 24'h800000, 24'h7FFFFF, 24'h800000, 24'h123456, 24'hABCDEF, 24'h555555, 24'hAAAAAA},
        {24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF},
        {24'hA5A5A5, 24'h5A5A5A, 24'h0F0F0F, 24'hF0F0F0, 24'hC00003, 24'h3FFFFC, 24'h800001, 24'h7FFFFE}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0, dclk = 1'b0, dout = 1'b0;
    logic [TB-1:0] samples;
    logic frame_valid, filler_error, short_frame;

    int checks = 0, failures = 0;
    int fv_count = 0, run = 0, max_run = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fsync_adc_rx dut_i (
        .clk(clk), .rst_n(rst_n), .fsync_in(fsync), .dclk_in(dclk), .dout_in(dout),
        .samples_o(samples), .frame_valid_o(frame_valid),
        .filler_error_o(filler_error), .short_frame_o(short_frame)
    );

    always @(negedge clk) begin
        if (rst_n && frame_valid) begin
            fv_count <= fv_count + 1;
            run      <= run + 1;
            if (run + 1 > max_run) max_run <= run + 1;
        end else begin
            run <= 0;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [TB-1:0] act, input logic [TB-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic dbit(input logic b, input logic fs);
        @(negedge clk);
        dout = b; fsync = fs;
        repeat (4) @(negedge clk);
        dclk = 1'b1;
        repeat (4) @(negedge clk);
        dclk = 1'b0;
    endtask

    task automatic send(input logic [TB-1:0] w, input int nbits,
                        input logic [7:0] fill, input int nfill);
        for (int i = 0; i < nbits; i++) dbit(w[TB-1-i], i < 2);
        for (int j = 0; j < nfill; j++) dbit(fill[7-j], 1'b0);
        repeat (6) @(negedge clk);
    endtask

    task automatic check_channels(input string req, input logic [TB-1:0] exp);
        for (int ch = 0; ch < NCH; ch++)
            check(req, $sformatf("channel %0d", ch),
                  TB'(samples[(NCH-ch)*W-1 -: W]), TB'(exp[(NCH-ch)*W-1 -: W]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        // R1: outputs clear during reset
        check("R1", "samples in reset", samples, '0);
        check("R1", "flags in reset", TB'({frame_valid, filler_error, short_frame}), '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "flags after reset", TB'({frame_valid, filler_error, short_frame}), '0);

        // R2: bits before any frame-sync edge are ignored
        for (int i = 0; i < 30; i++) dbit(i[0], 1'b0);
        repeat (6) @(negedge clk);
        check("R2", "pulses before first frame", TB'(fv_count), '0);
        check("R2", "samples before first frame", samples, '0);

        // Table walk: R3, R4, R5, R6
        for (int v = 0; v < NVEC; v++) begin
            base = fv_count;
            send(VEC[v], TB, 8'hFF, 8);
            check("R4", $sformatf("pulse count vec %0d", v), TB'(fv_count - base), TB'(1));
            check("R3", $sformatf("word order vec %0d", v), samples, VEC[v]);
            check_channels("R5", VEC[v]);
            check("R6", $sformatf("filler error vec %0d", v), TB'(filler_error), '0);
        end
        check("R4", "pulse width", TB'(max_run), TB'(1));
        for (int i = 0; i < 12; i++) dbit(1'b1, 1'b0);
        check("R4", "hold between frames", samples, VEC[NVEC-1]);
        check("R8", "short flag before short frame", TB'(short_frame), '0);

        // R8/R9: truncated frame then a full one
        base = fv_count;
        send(VEC[0], 100, 8'hFF, 0);
        check("R8", "no pulse on partial", TB'(fv_count - base), '0);
        check("R8", "samples unchanged on partial", samples, VEC[NVEC-1]);
        send(VEC[1], TB, 8'hFF, 8);
        check("R8", "short flag set", TB'(short_frame), TB'(1));
        check("R9", "one pulse after recovery", TB'(fv_count - base), TB'(1));
        check("R9", "recovered frame", samples, VEC[1]);

        // R7: a zero among trailing bits, then stickiness
        send(VEC[2], TB, 8'b1110_1111, 8);
        check("R7", "filler error set", TB'(filler_error), TB'(1));
        send(VEC[3], TB, 8'hFF, 8);
        check("R7", "filler error sticky", TB'(filler_error), TB'(1));
        check("R3", "frame after filler error", samples, VEC[3]);
        check("R8", "short flag sticky", TB'(short_frame), TB'(1));

        // R1: reset clears sticky flags and words
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "flags after second reset", TB'({frame_valid, filler_error, short_frame}), '0);
        check("R1", "samples after second reset", samples, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule